// File: doc/BRIEF.md
# Descriptor Cache Flush Sequencer

This block takes flush commands for a descriptor cache and runs each one to completion. A command names a 40-bit descriptor address and a set of control bits. The controller can first ask the reorder-queue logic to drain every entry held for that descriptor. It then issues one flush request to the cache, with or without invalidating the line. After the flush it can keep the address locked out of the cache. The lock-out is recorded in one of four software-assigned blocking slots and lasts until an explicit unblock.

A whole-cache flush variant writes out every line and then puts a global block on the cache. That block lasts until an unblock command of the cache type arrives. The variant ignores every other control field and leaves the four slots exactly as they were. Other cache users ask the block, through a combinational query port, whether an address is currently locked. Every command and every unblock ends with a one-cycle status pulse carrying a success or error code.

Top module: `flush_cmd_ctrl`

## Requirements
- R1: The flush address is assembled as {cmd_ctrl[7:0], cmd_addr_lo[31:0]}. The same address appears on fl_addr and drain_addr, and it stays stable while fl_req waits for fl_ack.
- R2: Only one operation is in flight at a time. cmd_ready and unblk_ready are low while drain_req or fl_req is high. When unblk_valid and cmd_valid are both high while idle, the unblock is taken and cmd_ready stays low.
- R3: cmd_ctrl bit 9 (release) asks the slot chosen by bits 11:10 to be freed first. If that slot is already free, the command returns status 2'b01, issues neither drain nor flush, and changes no slot.
- R4: A release of a held slot frees it at acceptance. The command then runs normally, and the query port stops reporting the old address.
- R5: cmd_ctrl bit 13 (block after flush) on a slot that is still held and not released by the same command returns status 2'b10. That command issues no drain and no flush, and the slot keeps its old address.
- R6: A successful block-after-flush stores the address in the chosen slot when fl_ack arrives. From then on q_blocked is high for that address until the slot is freed.
- R7: With cmd_ctrl bit 8 (drain) set, drain_req is held until drain_done. fl_req rises only in the cycle after drain_done and is never high together with drain_req. Without bit 8, no drain is requested.
- R8: cmd_ctrl bit 12 (keep line) sets fl_inval low; otherwise fl_inval is high. A whole-cache flush always has fl_inval high.
- R9: cmd_ctrl bit 14 (whole cache) sets fl_all and skips the drain, the release check and the block check. It ends with status 2'b00, and q_blocked is high for every address until a cache-type unblock. The four slots are unchanged afterwards.
- R10: On the unblock port, unblk_cache=1 clears the global block and returns 2'b00. unblk_cache=0 frees slot unblk_idx and returns 2'b00, or returns 2'b01 if that slot was already free.
- R11: stat_valid is a one-cycle pulse in the cycle after the completing edge: the fl_ack edge, or the acceptance edge for errors and unblocks. stat_code is 2'b00, 2'b01 or 2'b10, never 2'b11.
- R12: After reset no slot is held, the cache is not blocked, no request is raised, and cmd_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Flush command offered |
| cmd_ready | output | 1 | Flush command accepted this cycle when both are high |
| cmd_addr_lo | input | 32 | Address bits 31:0 |
| cmd_ctrl | input | 15 | Bits 7:0 address bits 39:32, 8 drain, 9 release, 11:10 slot, 12 keep line, 13 block after flush, 14 whole cache |
| unblk_valid | input | 1 | Unblock command offered |
| unblk_ready | output | 1 | Unblock accepted when both are high |
| unblk_cache | input | 1 | 1 clears the global block, 0 frees one slot |
| unblk_idx | input | 2 | Slot to free |
| drain_req | output | 1 | Request to drain the queue of drain_addr |
| drain_addr | output | 40 | Descriptor whose queue is drained |
| drain_done | input | 1 | Drain finished |
| fl_req | output | 1 | Flush request to the cache |
| fl_addr | output | 40 | Line to flush |
| fl_inval | output | 1 | Invalidate the line after writing it out |
| fl_all | output | 1 | Flush every line |
| fl_ack | input | 1 | Flush finished |
| q_addr | input | 40 | Address being looked up by a cache user |
| q_blocked | output | 1 | q_addr is locked (slot match or global block) |
| stat_valid | output | 1 | Completion pulse |
| stat_code | output | 2 | 00 ok, 01 release of a free slot, 10 block of a held slot |

## Verification
The hardest state to reach is a slot held with one address while a command both releases it and re-blocks it with another address. Close by sits a whole-cache flush issued while slots are held and carrying a release bit that would be an error in a normal command. Random stimulus reaches these only with a narrow address pool and a small slot count, so the stimulus draws addresses from six values and all four slots. Directed sequences build the held-then-released and global-block-over-held-slots cases explicitly. The query port is then swept over the pool after every operation.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
    localparam int WORD_W  = 32;
    localparam int ADDR_W  = 40;
    localparam int HI_W    = ADDR_W - WORD_W;
    localparam int NRES    = 4;
    localparam int RIDX_W  = $clog2(NRES);
    localparam int CTRL_W  = 15;

    localparam int B_DRAIN = 8;
    localparam int B_REL   = 9;
    localparam int B_IDX   = 10;
    localparam int B_KEEP  = 12;
    localparam int B_BLK   = 13;
    localparam int B_ALL   = 14;

    localparam logic [1:0] ST_OK      = 2'b00;
    localparam logic [1:0] ST_ERR_REL = 2'b01;
    localparam logic [1:0] ST_ERR_BLK = 2'b10;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              drain;
        logic              rel;
        logic [RIDX_W-1:0] ridx;
        logic              keep;
        logic              blk;
        logic              all;
    } cmd_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DRAIN = 2'd1,
        PH_FLUSH = 2'd2
    } phase_e;
endpackage

// File: rtl/fcc_decode.sv
module fcc_decode
    import fcc_pkg::*;
(
    input  logic [WORD_W-1:0] addr_lo,
    input  logic [CTRL_W-1:0] ctrl,
    output cmd_t              cmd
);
    always_comb begin
        cmd       = '0;
        cmd.addr  = {ctrl[HI_W-1:0], addr_lo};
        cmd.drain = ctrl[B_DRAIN];
        cmd.rel   = ctrl[B_REL];
        cmd.ridx  = ctrl[B_IDX +: RIDX_W];
        cmd.keep  = ctrl[B_KEEP];
        cmd.blk   = ctrl[B_BLK];
        cmd.all   = ctrl[B_ALL];
    end
endmodule

// File: rtl/fcc_res_table.sv
module fcc_res_table
    import fcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rel_en,
    input  logic [RIDX_W-1:0] rel_idx,
    input  logic              set_en,
    input  logic [RIDX_W-1:0] set_idx,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic [ADDR_W-1:0] q_addr,
    output logic [NRES-1:0]   held,
    output logic              q_hit
);
    typedef struct packed {
        logic [NRES-1:0]             held;
        logic [NRES-1:0][ADDR_W-1:0] addr;
    } tbl_t;

    tbl_t tbl_d, tbl_q;
    logic [NRES-1:0] hit;

    always_comb begin
        tbl_d = tbl_q;
        for (int i = 0; i < NRES; i++) begin
            if (rel_en && rel_idx == RIDX_W'(i)) begin
                tbl_d.held[i] = 1'b0;
            end
            if (set_en && set_idx == RIDX_W'(i)) begin
                tbl_d.held[i] = 1'b1;
                tbl_d.addr[i] = set_addr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    for (genvar g = 0; g < NRES; g++) begin : g_match
        assign hit[g] = tbl_q.held[g] && (tbl_q.addr[g] == q_addr);
    end

    assign held  = tbl_q.held;
    assign q_hit = |hit;
endmodule

// File: rtl/fcc_seq.sv
module fcc_seq
    import fcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  cmd_t              cmd,
    output logic              cmd_ready,
    input  logic              unblk_valid,
    input  logic              unblk_cache,
    input  logic [RIDX_W-1:0] unblk_idx,
    output logic              unblk_ready,
    input  logic [NRES-1:0]   held,
    output logic              drain_req,
    output logic [ADDR_W-1:0] drain_addr,
    input  logic              drain_done,
    output logic              fl_req,
    output logic [ADDR_W-1:0] fl_addr,
    output logic              fl_inval,
    output logic              fl_all,
    input  logic              fl_ack,
    output logic              rel_en,
    output logic [RIDX_W-1:0] rel_idx,
    output logic              set_en,
    output logic [RIDX_W-1:0] set_idx,
    output logic [ADDR_W-1:0] set_addr,
    output logic              cache_blk,
    output logic              stat_valid,
    output logic [1:0]        stat_code
);
    typedef struct packed {
        phase_e     ph;
        cmd_t       cur;
        logic       cblk;
        logic       sv;
        logic [1:0] sc;
    } seq_t;

    seq_t s_d, s_q;
    logic idle;

    assign idle = (s_q.ph == PH_IDLE);

    always_comb begin
        s_d     = s_q;
        s_d.sv  = 1'b0;
        rel_en  = 1'b0;
        rel_idx = '0;
        set_en  = 1'b0;
        set_idx = s_q.cur.ridx;
        set_addr = s_q.cur.addr;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (unblk_valid) begin
                    s_d.sv = 1'b1;
                    if (unblk_cache) begin
                        s_d.cblk = 1'b0;
                        s_d.sc   = ST_OK;
                    end else if (!held[unblk_idx]) begin
                        s_d.sc = ST_ERR_REL;
                    end else begin
                        rel_en  = 1'b1;
                        rel_idx = unblk_idx;
                        s_d.sc  = ST_OK;
                    end
                end else if (cmd_valid) begin
                    s_d.cur = cmd;
                    if (cmd.all) begin
                        s_d.ph = PH_FLUSH;
                    end else if (cmd.rel && !held[cmd.ridx]) begin
                        s_d.sv = 1'b1;
                        s_d.sc = ST_ERR_REL;
                    end else if (cmd.blk && !cmd.rel && held[cmd.ridx]) begin
                        s_d.sv = 1'b1;
                        s_d.sc = ST_ERR_BLK;
                    end else begin
                        rel_en  = cmd.rel;
                        rel_idx = cmd.ridx;
                        s_d.ph  = cmd.drain ? PH_DRAIN : PH_FLUSH;
                    end
                end
            end
            PH_DRAIN: begin
                if (drain_done) begin
                    s_d.ph = PH_FLUSH;
                end
            end
            PH_FLUSH: begin
                if (fl_ack) begin
                    s_d.ph = PH_IDLE;
                    s_d.sv = 1'b1;
                    s_d.sc = ST_OK;
                    if (s_q.cur.all) begin
                        s_d.cblk = 1'b1;
                    end else if (s_q.cur.blk) begin
                        set_en = 1'b1;
                    end
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, cur: '0, cblk: 1'b0, sv: 1'b0, sc: ST_OK};
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_ready   = idle && !unblk_valid;
    assign unblk_ready = idle;
    assign drain_req   = (s_q.ph == PH_DRAIN);
    assign drain_addr  = s_q.cur.addr;
    assign fl_req      = (s_q.ph == PH_FLUSH);
    assign fl_addr     = s_q.cur.addr;
    assign fl_all      = s_q.cur.all;
    assign fl_inval    = s_q.cur.all || !s_q.cur.keep;
    assign cache_blk   = s_q.cblk;
    assign stat_valid  = s_q.sv;
    assign stat_code   = s_q.sc;
endmodule

// File: rtl/flush_cmd_ctrl.sv
module flush_cmd_ctrl
    import fcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [WORD_W-1:0] cmd_addr_lo,
    input  logic [CTRL_W-1:0] cmd_ctrl,
    input  logic              unblk_valid,
    output logic              unblk_ready,
    input  logic              unblk_cache,
    input  logic [RIDX_W-1:0] unblk_idx,
    output logic              drain_req,
    output logic [ADDR_W-1:0] drain_addr,
    input  logic              drain_done,
    output logic              fl_req,
    output logic [ADDR_W-1:0] fl_addr,
    output logic              fl_inval,
    output logic              fl_all,
    input  logic              fl_ack,
    input  logic [ADDR_W-1:0] q_addr,
    output logic              q_blocked,
    output logic              stat_valid,
    output logic [1:0]        stat_code
);
    cmd_t              cmd;
    logic [NRES-1:0]   held;
    logic              rel_en, set_en, cache_blk, q_hit;
    logic [RIDX_W-1:0] rel_idx, set_idx;
    logic [ADDR_W-1:0] set_addr;

    fcc_decode i_dec (
        .addr_lo (cmd_addr_lo),
        .ctrl    (cmd_ctrl),
        .cmd     (cmd)
    );

    fcc_seq i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd         (cmd),
        .cmd_ready   (cmd_ready),
        .unblk_valid (unblk_valid),
        .unblk_cache (unblk_cache),
        .unblk_idx   (unblk_idx),
        .unblk_ready (unblk_ready),
        .held        (held),
        .drain_req   (drain_req),
        .drain_addr  (drain_addr),
        .drain_done  (drain_done),
        .fl_req      (fl_req),
        .fl_addr     (fl_addr),
        .fl_inval    (fl_inval),
        .fl_all      (fl_all),
        .fl_ack      (fl_ack),
        .rel_en      (rel_en),
        .rel_idx     (rel_idx),
        .set_en      (set_en),
        .set_idx     (set_idx),
        .set_addr    (set_addr),
        .cache_blk   (cache_blk),
        .stat_valid  (stat_valid),
        .stat_code   (stat_code)
    );

    fcc_res_table i_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rel_en   (rel_en),
        .rel_idx  (rel_idx),
        .set_en   (set_en),
        .set_idx  (set_idx),
        .set_addr (set_addr),
        .q_addr   (q_addr),
        .held     (held),
        .q_hit    (q_hit)
    );

    assign q_blocked = cache_blk || q_hit;
endmodule

// File: rtl/fcc_checker.sv
module fcc_checker
    import fcc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready,
    input logic              unblk_ready,
    input logic              drain_req,
    input logic              drain_done,
    input logic              fl_req,
    input logic [ADDR_W-1:0] fl_addr,
    input logic              fl_inval,
    input logic              fl_all,
    input logic              fl_ack,
    input logic              q_blocked,
    input logic              stat_valid,
    input logic [1:0]        stat_code
);
    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        drain_req |-> !fl_req); // R7
    AST_DRAIN_THEN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        drain_req && drain_done |=> fl_req); // R7
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_req || fl_req) |-> !cmd_ready && !unblk_ready); // R2
    AST_FLUSH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req && !fl_ack |=> fl_req && $stable(fl_addr) && $stable(fl_all)); // R1
    AST_ALL_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req && fl_all |-> fl_inval); // R8
    AST_ALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req && fl_ack && fl_all |=> q_blocked); // R9
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> stat_code != 2'b11); // R11
    AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid && stat_code != 2'b00 |-> !drain_req && !fl_req); // R3
endmodule

bind flush_cmd_ctrl fcc_checker i_fcc_checker (.*);

// File: tb/test_flush_cmd_ctrl.sv
module test_flush_cmd_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_addr_lo = '0;
    logic [14:0] cmd_ctrl = '0;
    logic        unblk_valid = 1'b0;
    logic        unblk_ready;
    logic        unblk_cache = 1'b0;
    logic [1:0]  unblk_idx = '0;
    logic        drain_req;
    logic [39:0] drain_addr;
    logic        drain_done = 1'b0;
    logic        fl_req;
    logic [39:0] fl_addr;
    logic        fl_inval;
    logic        fl_all;
    logic        fl_ack = 1'b0;
    logic [39:0] q_addr = '0;
    logic        q_blocked;
    logic        stat_valid;
    logic [1:0]  stat_code;

    int total = 0;
    int bad = 0;

    bit          m_held [4];
    logic [39:0] m_addr [4];
    bit          m_cblk;

    always #4 clk = ~clk;

    flush_cmd_ctrl i_flush_cmd_ctrl (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [39:0] pool(input int i);
        return {8'(8'hA0 + i), 32'h1000_0000 + 32'(i) * 32'h44};
    endfunction

    function automatic bit exp_blocked(input logic [39:0] a);
        bit r = m_cblk;
        for (int i = 0; i < 4; i++) if (m_held[i] && m_addr[i] == a) r = 1'b1;
        return r;
    endfunction

    task automatic sweep_queries(input string req);
        for (int i = 0; i < 7; i++) begin
            logic [39:0] a = (i < 6) ? pool(i) : {8'h3C, $urandom()};
            q_addr = a;
            #1;
            chk(q_blocked == exp_blocked(a), req, "q_blocked", 64'(q_blocked), 64'(exp_blocked(a)));
        end
    endtask

    task automatic do_cmd(input logic [39:0] a, input bit drn, input bit rel, input logic [1:0] idx,
                          input bit keep, input bit blk, input bit all, input string req);
        logic [1:0] ecode;
        bit edrain, eflush, sdrain, sflush, got, fchk, order_ok;
        logic [1:0] code;
        if (all) ecode = 2'b00;
        else if (rel && !m_held[idx]) ecode = 2'b01;
        else if (blk && !rel && m_held[idx]) ecode = 2'b10;
        else ecode = 2'b00;
        eflush = (ecode == 2'b00);
        edrain = eflush && !all && drn;
        sdrain = 0; sflush = 0; got = 0; fchk = 0; order_ok = 1; code = 2'b11;
        @(negedge clk);
        cmd_addr_lo = a[31:0];
        cmd_ctrl = {all, blk, keep, idx, rel, drn, a[39:32]};
        cmd_valid = 1'b1;
        #1;
        chk(cmd_ready == 1'b1, "R2", "ready when idle", 64'(cmd_ready), 64'd1);
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int k = 0; k < 300; k++) begin
            if (k != 0) @(negedge clk);
            drain_done = 1'b0;
            fl_ack = 1'b0;
            #1;
            if (stat_valid) begin
                got = 1; code = stat_code;
                break;
            end
            if (drain_req || fl_req) begin
                if (cmd_ready || unblk_ready) order_ok = 0;
            end
            if (drain_req) begin
                if (fl_req || sflush) order_ok = 0;
                if (!sdrain) chk(drain_addr == a, "R1", "drain_addr", 64'(drain_addr), 64'(a));
                sdrain = 1;
                if ($urandom_range(2) == 0) drain_done = 1'b1;
            end else if (fl_req) begin
                sflush = 1;
                if (!fchk) begin
                    fchk = 1;
                    chk(fl_all == all, req, "fl_all", 64'(fl_all), 64'(all));
                    chk(fl_inval == (all || !keep), "R8", "fl_inval", 64'(fl_inval), 64'(all || !keep));
                    if (!all) chk(fl_addr == a, "R1", "fl_addr", 64'(fl_addr), 64'(a));
                end
                if ($urandom_range(2) == 0) fl_ack = 1'b1;
            end
        end
        chk(got, "R11", "status pulse seen", 64'(got), 64'd1);
        chk(code == ecode, req, "stat_code", 64'(code), 64'(ecode));
        chk(sdrain == edrain, "R7", "drain issued", 64'(sdrain), 64'(edrain));
        chk(sflush == eflush, req, "flush issued", 64'(sflush), 64'(eflush));
        chk(order_ok, "R2", "busy excludes ready and drain precedes flush", 64'(order_ok), 64'd1);
        @(negedge clk);
        #1;
        chk(stat_valid == 1'b0, "R11", "pulse length", 64'(stat_valid), 64'd0);
        if (ecode == 2'b00) begin
            if (all) m_cblk = 1;
            else begin
                if (rel) m_held[idx] = 0;
                if (blk) begin m_held[idx] = 1; m_addr[idx] = a; end
            end
        end
    endtask

    task automatic do_unblk(input bit cache, input logic [1:0] idx);
        logic [1:0] ecode = (!cache && !m_held[idx]) ? 2'b01 : 2'b00;
        @(negedge clk);
        unblk_valid = 1'b1; unblk_cache = cache; unblk_idx = idx;
        #1;
        chk(unblk_ready == 1'b1, "R10", "unblk_ready", 64'(unblk_ready), 64'd1);
        @(negedge clk);
        unblk_valid = 1'b0;
        #1;
        chk(stat_valid == 1'b1, "R11", "unblock pulse", 64'(stat_valid), 64'd1);
        chk(stat_code == ecode, "R10", "unblock code", 64'(stat_code), 64'(ecode));
        if (cache) m_cblk = 0;
        else m_held[idx] = 0;
    endtask

    initial begin
        #(8 * 150000);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int i = 0; i < 4; i++) begin m_held[i] = 0; m_addr[i] = '0; end
        m_cblk = 0;
        repeat (3) @(negedge clk);
        #1;
        chk(cmd_ready == 1 && drain_req == 0 && fl_req == 0 && stat_valid == 0, "R12", "reset outputs",
            {cmd_ready, drain_req, fl_req, stat_valid}, 64'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        sweep_queries("R12");

        // R3: release of a free slot
        do_cmd(pool(0), 1, 1, 2'd1, 0, 1, 0, "R3");
        sweep_queries("R3");
        // R6: block slot 2 with pool(1), drain first (R7), keep line (R8)
        do_cmd(pool(1), 1, 0, 2'd2, 1, 1, 0, "R6");
        sweep_queries("R6");
        // R5: block on held slot without release
        do_cmd(pool(2), 0, 0, 2'd2, 0, 1, 0, "R5");
        sweep_queries("R5");
        // R4: release and re-block slot 2 with pool(3)
        do_cmd(pool(3), 0, 1, 2'd2, 0, 1, 0, "R4");
        sweep_queries("R4");
        // R9: whole cache, release bit on a free slot must be ignored
        do_cmd(pool(4), 1, 1, 2'd0, 1, 1, 1, "R9");
        sweep_queries("R9");
        // R2: unblock wins over a command when both are offered
        @(negedge clk);
        cmd_valid = 1'b1; unblk_valid = 1'b1; unblk_cache = 1'b1; cmd_ctrl = '0;
        #1;
        chk(cmd_ready == 1'b0, "R2", "cmd_ready under unblock", 64'(cmd_ready), 64'd0);
        @(negedge clk);
        cmd_valid = 1'b0; unblk_valid = 1'b0;
        #1;
        chk(stat_valid && stat_code == 2'b00, "R10", "cache unblock status", {stat_valid, stat_code}, 64'b100);
        m_cblk = 0;
        sweep_queries("R9");
        // R10: free a free slot, then free the held slot
        do_unblk(0, 2'd3);
        do_unblk(0, 2'd2);
        sweep_queries("R10");

        for (int n = 0; n < 600; n++) begin
            int pick = $urandom_range(9);
            if (pick < 2) begin
                do_unblk($urandom_range(3) == 0, 2'($urandom_range(3)));
            end else begin
                do_cmd(pool($urandom_range(5)), $urandom_range(1) == 1, $urandom_range(2) == 0,
                       2'($urandom_range(3)), $urandom_range(1) == 1, $urandom_range(1) == 1,
                       $urandom_range(9) == 0, "R6");
            end
            sweep_queries("R6");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule